// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Stage

This block sits in the memory stage of a five-stage integer pipeline. Its job is to move 8-, 16- and 32-bit data between the register view and a 32-bit little-endian data memory. It takes one request per cycle, consisting of a valid bit, the load and store intents, an access size, a sign flag, the ALU result (which is the byte address on memory operations) and the register value to store.

In the same cycle, it drives a word-aligned address, lane-replicated write data and byte enables toward the data memory. The memory answers in that cycle. The stage then registers one result for write-back:

- For a load, the addressed lane is shifted down to bit 0 and then zero- or sign-extended.
- For every other instruction, the ALU value is passed through unchanged.

Every instruction therefore leaves the stage exactly one clock after it entered, whether or not it touched memory. A halfword or word request whose address is not naturally aligned never reaches memory. Instead it reports an alignment error with the result.

Top module: `lsu_lane_align`

## Requirements
- R1: While rst_n is low, res_valid, res_data and res_misalign are all zero.
- R2: A valid request with neither ld nor st registers res_data equal to alu_addr on the next clock edge, with res_misalign low and no memory strobe raised.
- R3: Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. An aligned byte store drives dm_wdata as the low byte copied to all four lanes, and dm_be as the single bit numbered by alu_addr[1:0].
- R4: An aligned halfword store drives dm_wdata as the low halfword copied to both halves, and dm_be as 4'b0011 when alu_addr[1] is 0 or 4'b1100 when it is 1.
- R5: An aligned word store drives dm_wdata equal to st_data and dm_be equal to 4'b1111.
- R6: A halfword with alu_addr[0]=1, or a word with alu_addr[1:0]≠0, is misaligned when ld or st is set. Such a request drives dm_we, dm_re and dm_be low, and one cycle later gives res_misalign=1 with res_data=0.
- R7: An aligned byte load returns byte lane alu_addr[1:0] of dm_rdata in res_data[7:0]. The upper bits are copies of bit 7 when ld_signed=1 and zeros otherwise.
- R8: An aligned halfword load returns dm_rdata half alu_addr[1] in res_data[15:0]. The upper bits are sign- or zero-filled according to ld_signed.
- R9: An aligned word load returns dm_rdata unchanged in res_data.
- R10: dm_addr is alu_addr with bits [1:0] cleared. dm_re is high only for a valid aligned load. When ld and st are both set, the request is a load and dm_we stays low.
- R11: res_valid equals req_valid of the previous cycle. In a cycle without a valid request, res_data is registered as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction present in the stage |
| ld | input | 1 | Load request |
| st | input | 1 | Store request |
| size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| ld_signed | input | 1 | Sign-extend narrow loads |
| alu_addr | input | ADDR_W | ALU result / byte address |
| st_data | input | 32 | Register value to store |
| dm_addr | output | ADDR_W | Word-aligned memory address |
| dm_re | output | 1 | Memory read strobe |
| dm_we | output | 1 | Memory write strobe |
| dm_be | output | 4 | Byte-lane write enables |
| dm_wdata | output | 32 | Lane-replicated write data |
| dm_rdata | input | 32 | Memory read word, same cycle |
| res_valid | output | 1 | Result valid for write-back |
| res_data | output | 32 | Aligned load data or passed ALU value |
| res_misalign | output | 1 | Alignment error for the result |

## Verification
The memory-side outputs (address, strobes, byte enables and write data) are combinational from the request. The bench drives each request on a falling edge and checks them one time unit later, in the same cycle. The registered results (valid, data, alignment error) are due after the following rising edge, and the bench samples them two time units after that edge. A swept request is never compared against a value from a different cycle. The sweep covers every lane offset, every size code, both sign settings, loads, stores, passes, idle cycles and the combined load-and-store case. It runs at two address bases, so both sign polarities appear in every lane.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              ld,
  input  logic              st,
  input  logic [1:0]        size,
  input  logic              ld_signed,
  input  logic [ADDR_W-1:0] alu_addr,
  input  logic [31:0]       st_data,
  output logic [ADDR_W-1:0] dm_addr,
  output logic              dm_re,
  output logic              dm_we,
  output logic [3:0]        dm_be,
  output logic [31:0]       dm_wdata,
  input  logic [31:0]       dm_rdata,
  output logic              res_valid,
  output logic [31:0]       res_data,
  output logic              res_misalign
);
  localparam int LANES = 4;
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0] ofs;
  logic             sz_byte, sz_half, sz_word;
  logic             bad_align, mem_op, err_now;
  logic [LANES-1:0] lane_sel;
  logic [31:0]      shifted, ld_val, next_data;

  assign ofs     = alu_addr[OFS_W-1:0];
  assign sz_byte = (size == 2'd0);
  assign sz_half = (size == 2'd1);
  assign sz_word = size[1];

  assign bad_align = (sz_half & ofs[0]) | (sz_word & (|ofs));
  assign mem_op    = req_valid & (ld | st);
  assign err_now   = mem_op & bad_align;

  assign dm_addr = {alu_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign dm_re   = req_valid & ld & ~bad_align;
  assign dm_we   = req_valid & st & ~ld & ~bad_align;

  assign dm_wdata = sz_byte ? {LANES{st_data[7:0]}} :
                    sz_half ? {2{st_data[15:0]}}    : st_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_sel[i] = sz_word
                       | (sz_half & (ofs[1] == i[1]))
                       | (sz_byte & (ofs == i[OFS_W-1:0]));
  end
  assign dm_be = dm_we ? lane_sel : '0;

  assign shifted = dm_rdata >> {ofs, 3'b000};

  always_comb begin
    if (sz_byte)
      ld_val = {{24{ld_signed & shifted[7]}}, shifted[7:0]};
    else if (sz_half)
      ld_val = {{16{ld_signed & shifted[15]}}, shifted[15:0]};
    else
      ld_val = dm_rdata;
  end

  always_comb begin
    if (!req_valid || err_now) next_data = '0;
    else if (ld)               next_data = ld_val;
    else                       next_data = 32'(alu_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_misalign <= 1'b0;
    end else begin
      res_valid    <= req_valid;
      res_data     <= next_data;
      res_misalign <= err_now;
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ld,
  input logic              st,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] alu_addr,
  input logic              dm_re,
  input logic              dm_we,
  input logic [3:0]        dm_be,
  input logic              res_valid,
  input logic [31:0]       res_data,
  input logic              res_misalign
);
  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ld && !st) |=> (res_data == 32'($past(alu_addr)) && !res_misalign));

  assert_byte_be_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_we && size == 2'd0) |-> ($countones(dm_be) == 1));

  assert_word_be_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_we && size[1]) |-> (dm_be == 4'hF));

  assert_misalign_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (ld || st) && size[1] && alu_addr[1:0] != 2'b00) |=> (res_misalign && res_data == 32'd0));

  assert_misalign_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd1 && alu_addr[0]) |-> (!dm_we && !dm_re && dm_be == 4'h0));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !dm_we);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(req_valid)));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ld(ld), .st(st),
  .size(size), .alu_addr(alu_addr), .dm_re(dm_re), .dm_we(dm_we),
  .dm_be(dm_be), .res_valid(res_valid), .res_data(res_data),
  .res_misalign(res_misalign)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, ld = 1'b0, st = 1'b0, ld_signed = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] alu_addr = '0, st_data = '0;
  logic [31:0] dm_addr, dm_wdata, dm_rdata, res_data;
  logic        dm_re, dm_we, res_valid, res_misalign;
  logic [3:0]  dm_be;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign dm_rdata = dm_addr ^ 32'h81F2_6C93;

  lsu_lane_align #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ld(ld), .st(st),
    .size(size), .ld_signed(ld_signed), .alu_addr(alu_addr), .st_data(st_data),
    .dm_addr(dm_addr), .dm_re(dm_re), .dm_we(dm_we), .dm_be(dm_be),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .res_valid(res_valid),
    .res_data(res_data), .res_misalign(res_misalign)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic v, input logic l, input logic s, input logic [1:0] sz,
                    input logic sg, input logic [31:0] a, input logic [31:0] d);
    int bytes, o, sh;
    logic mis, do_ld, do_st;
    logic [3:0] be;
    logic [31:0] wd, word, pick, res;
    @(negedge clk);
    req_valid = v; ld = l; st = s; size = sz; ld_signed = sg; alu_addr = a; st_data = d;
    bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    o = int'(a % 4);
    mis = (o % bytes) != 0;
    do_ld = v && l && !mis;
    do_st = v && s && !l && !mis;
    be = 4'((2 ** bytes) - 1) << o;
    if (bytes == 1)      wd = d[7:0] * 32'h0101_0101;
    else if (bytes == 2) wd = d[15:0] * 32'h0001_0001;
    else                 wd = d;
    word = (a - 32'(o)) ^ 32'h81F2_6C93;
    pick = (word / (32'd1 << (8 * o)));
    if (bytes == 1) begin
      pick = pick % 256;
      if (sg && pick >= 128) pick = pick - 256;
    end else if (bytes == 2) begin
      pick = pick % 65536;
      if (sg && pick >= 32768) pick = pick - 65536;
    end
    if (!v || ((l || s) && mis)) res = 0;
    else if (l) res = pick;
    else res = a;
    #1;
    chk("R10 dm_addr", dm_addr, a - 32'(o));
    chk("R10 dm_re", 32'(dm_re), 32'(do_ld));
    chk("R6/R10 dm_we", 32'(dm_we), 32'(do_st));
    chk(bytes == 1 ? "R3 dm_be" : bytes == 2 ? "R4 dm_be" : "R5 dm_be",
        32'(dm_be), do_st ? 32'(be) : 32'd0);
    if (do_st)
      chk(bytes == 1 ? "R3 dm_wdata" : bytes == 2 ? "R4 dm_wdata" : "R5 dm_wdata", dm_wdata, wd);
    @(posedge clk);
    #2;
    sh = 0;
    chk("R11 res_valid", 32'(res_valid), 32'(v));
    chk("R6 res_misalign", 32'(res_misalign), 32'(v && (l || s) && mis));
    if (v && l && !mis)
      chk(bytes == 1 ? "R7 res_data" : bytes == 2 ? "R8 res_data" : "R9 res_data", res_data, res);
    else if (v && (l || s) && mis)
      chk("R6 res_data", res_data, res);
    else if (v)
      chk("R2 res_data", res_data, res);
    else
      chk("R11 res_data idle", res_data, res);
    sh = sh + 1;
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bases [2];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'hFFFF_FFF0;
    #13;
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 res_data", res_data, 32'd0);
    chk("R1 res_misalign", 32'(res_misalign), 32'd0);
    #10 rst_n = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 4; o++)
        for (int sz = 0; sz < 4; sz++)
          for (int sg = 0; sg < 2; sg++)
            for (int kind = 0; kind < 5; kind++) begin
              case (kind)
                0: op(1'b1, 1'b1, 1'b0, 2'(sz), 1'(sg), bases[b] + 32'(o), 32'hA5C3_96F1);
                1: op(1'b1, 1'b0, 1'b1, 2'(sz), 1'(sg), bases[b] + 32'(o), 32'h5E7B_C2D4 ^ 32'(o));
                2: op(1'b1, 1'b0, 1'b0, 2'(sz), 1'(sg), bases[b] + 32'(o), 32'hFFFF_FFFF);
                3: op(1'b0, 1'b1, 1'b1, 2'(sz), 1'(sg), bases[b] + 32'(o), 32'h1234_5678);
                default: op(1'b1, 1'b1, 1'b1, 2'(sz), 1'(sg), bases[b] + 32'(o), 32'h0BAD_F00D);
              endcase
            end
    op(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'hDEAD_BEEF, 32'd0);
    op(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'hDEAD_BEEF, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule